// File: doc/BRIEF.md
# Subtractive GCD Engine

This block finds the greatest common divisor of two unsigned operands through repeated subtraction, taking several clock cycles per result. A host waits until `ready` is high and then presents the two operands together with a one-cycle `start`. The block copies the operands into two working registers and then loops. In each pass it tests whether the two registers are equal. If they are not, it moves the larger value into the first register, then subtracts the second register from the first and writes the difference back into the first.

When the two registers become equal, the common value is written to `r` and `done` pulses for one cycle. The block then goes back to idle. `r` keeps its value until the next computation finishes. When either operand is zero, the block skips the loop and finishes at once with the other operand. This also means the loop can never run forever.

The exchange and the subtraction each take one cycle. The latency therefore depends only on the number of subtractions the algorithm needs, and a host can work it out ahead of time.

Top module: `gcd_sub_top`

## Requirements
- R1: After synchronous active-high reset, `ready` is 1, `done` is 0 and `r` is 0.
- R2: `ready` is 1 only while the block is idle. It drops in the cycle after an accepted `start` and stays at 0 through the cycle in which `done` is high.
- R3: For two non-zero operands, `r` equals the greatest common divisor of `a_in` and `b_in` as they were when `start` was accepted.
- R4: Every subtraction takes the second working register from the first while the first holds the strictly larger value. When the second value is larger, the two are exchanged in the cycle before the subtraction.
- R5: With n subtractions needed, `done` is high exactly 2n+1 cycles after the clock edge that accepts `start`. Each subtraction costs one compare/exchange cycle and one subtract cycle, and the final equality test costs one more cycle.
- R6: When either operand is zero, `done` is high in the cycle right after the accepting edge, and `r` is the other operand (0 when both are zero).
- R7: `done` is high for exactly one cycle per computation.
- R8: `r` changes only in the cycle in which `done` is high, and keeps its value between completions.
- R9: A `start` seen while `ready` is 0 has no effect. The running computation's result and timing are unchanged.
- R10: Equal non-zero operands finish after one cycle of testing (n = 0), and `r` equals that operand.
- R11: Comparison and subtraction are unsigned over the full `WIDTH` bits, so operands with the top bit set give correct results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin; taken only while `ready` is 1 |
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| r | output | WIDTH | Result of the last completed computation |
| ready | output | 1 | Block is idle and will accept `start` |
| done | output | 1 | One-cycle pulse: `r` holds a fresh result |

## Verification
For every request, the bench runs the subtractive algorithm itself to count the subtractions n. From n it works out the cycle in which `done` is due: 2n+1 edges after the accepting edge, or the very next cycle when an operand is zero. The driver records that due cycle in a queue together with the expected result before it raises `start`. The monitor samples on the falling edge and compares both the result and the cycle count against the queued entry. A stray `start` during a busy run would change the arrival cycle, so the same timing check detects it.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SWAP = 2'd1,
    ST_SUB  = 2'd2,
    ST_DONE = 2'd3
  } gcd_state_e;
endpackage

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic in_zero,
  input  logic regs_eq,
  output logic load,
  output logic swap_en,
  output logic sub_en,
  output logic cap_reg,
  output logic cap_in,
  output logic ready,
  output logic done
);
  gcd_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    swap_en = 1'b0;
    sub_en  = 1'b0;
    cap_reg = 1'b0;
    cap_in  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (in_zero) begin
            cap_in  = 1'b1;
            state_d = ST_DONE;
          end else begin
            load    = 1'b1;
            state_d = ST_SWAP;
          end
        end
      end
      ST_SWAP: begin
        if (regs_eq) begin
          cap_reg = 1'b1;
          state_d = ST_DONE;
        end else begin
          swap_en = 1'b1;
          state_d = ST_SUB;
        end
      end
      ST_SUB: begin
        sub_en  = 1'b1;
        state_d = ST_SWAP;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign ready = (state_q == ST_IDLE);
  assign done  = (state_q == ST_DONE);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (ready && start && !in_zero) |=> (!ready && !done)); // R2
endmodule

// File: rtl/gcd_dpath.sv
module gcd_dpath #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             swap_en,
  input  logic             sub_en,
  input  logic             cap_reg,
  input  logic             cap_in,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic             in_zero,
  output logic             regs_eq,
  output logic [WIDTH-1:0] r
);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] x_q, y_q;
  logic             y_larger;
  logic [WIDTH-1:0] diff;

  assign in_zero  = (a_in == ZERO) || (b_in == ZERO);
  assign regs_eq  = (x_q == y_q);
  assign y_larger = (y_q > x_q);
  assign diff     = x_q - y_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= ZERO;
      y_q <= ZERO;
    end else if (load) begin
      x_q <= a_in;
      y_q <= b_in;
    end else if (swap_en && y_larger) begin
      x_q <= y_q;
      y_q <= x_q;
    end else if (sub_en) begin
      x_q <= diff;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          r <= ZERO;
    else if (cap_in)  r <= a_in | b_in;
    else if (cap_reg) r <= x_q;
  end

  AST_SUB_ORDER: assert property (@(posedge clk) disable iff (rst)
    sub_en |-> (x_q > y_q)); // R4

  AST_SWAP_MOVES_LARGER: assert property (@(posedge clk) disable iff (rst)
    (swap_en && y_larger) |=> (x_q == $past(y_q) && y_q == $past(x_q))); // R4
endmodule

// File: rtl/gcd_sub_top.sv
module gcd_sub_top #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] r,
  output logic             ready,
  output logic             done
);
  logic in_zero, regs_eq;
  logic load, swap_en, sub_en, cap_reg, cap_in;

  gcd_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .in_zero (in_zero),
    .regs_eq (regs_eq),
    .load    (load),
    .swap_en (swap_en),
    .sub_en  (sub_en),
    .cap_reg (cap_reg),
    .cap_in  (cap_in),
    .ready   (ready),
    .done    (done)
  );

  gcd_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .swap_en (swap_en),
    .sub_en  (sub_en),
    .cap_reg (cap_reg),
    .cap_in  (cap_in),
    .a_in    (a_in),
    .b_in    (b_in),
    .in_zero (in_zero),
    .regs_eq (regs_eq),
    .r       (r)
  );

  AST_ZERO_SHORTCUT: assert property (@(posedge clk) disable iff (rst)
    (ready && start && (a_in == '0 || b_in == '0)) |=>
      (done && r == $past(a_in | b_in))); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(r)); // R8
endmodule

// File: tb/gcd_sub_top_tb_top.sv
`timescale 1ns/1ps
module gcd_sub_top_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] r;
  logic         ready, done;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 1'b0;
  bit prev_done = 1'b0;
  logic [W-1:0] last_r = '0;

  logic [W-1:0] exp_r_q[$];
  int           exp_due_q[$];

  always #2 clk = ~clk;

  gcd_sub_top #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
    .r(r), .ready(ready), .done(done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Reference: subtractive algorithm with exchange, counts subtractions
  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] res, output int lat);
    logic [W-1:0] x, y, t;
    int n;
    if (a == 0 || b == 0) begin
      res = a | b;
      lat = 0;
    end else begin
      x = a; y = b; n = 0;
      while (x != y) begin
        if (y > x) begin t = x; x = y; y = t; end
        x = x - y;
        n++;
      end
      res = x;
      lat = 2 * n + 1;
    end
  endtask

  // Driver: called at a falling edge
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input bit intrude);
    logic [W-1:0] res;
    int lat;
    while (!ready) @(negedge clk);
    model(a, b, res, lat);
    exp_r_q.push_back(res);
    exp_due_q.push_back(cyc + 1 + lat);
    a_in = a; b_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(ready == 1'b0, "R2", ready, 0);
    if (intrude && lat > 3) begin
      @(negedge clk);
      a_in = '0; b_in = 16'd7; start = 1'b1;  // R9 stray start while busy
      @(negedge clk);
      start = 1'b0;
      check(ready == 1'b0, "R9", ready, 0);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_done) check(done == 1'b0, "R7", done, 0);
      prev_done = done;
      if (done) begin
        if (exp_r_q.size() == 0) begin
          check(1'b0, "R3", r, -1);
        end else begin
          logic [W-1:0] er;
          int due;
          er  = exp_r_q.pop_front();
          due = exp_due_q.pop_front();
          check(r == er, "R3 result", r, er);
          check(cyc == due, "R5 latency", cyc, due);
          check(ready == 1'b0, "R2 done cycle", ready, 0);
          last_r = er;
        end
      end else begin
        check(r == last_r, "R8", r, last_r);
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(ready == 1'b1, "R1 ready", ready, 1);
    check(done == 1'b0, "R1 done", done, 0);
    check(r == '0, "R1 r", r, 0);
    rst = 1'b0;
    @(negedge clk);
    issue(16'd48, 16'd18, 1'b0);     // R3
    issue(16'd18, 16'd48, 1'b0);     // R4 second larger
    issue(16'd17, 16'd5, 1'b0);      // R5
    issue(16'd100, 16'd100, 1'b0);   // R10
    issue(16'd0, 16'd9, 1'b0);       // R6
    issue(16'd9, 16'd0, 1'b0);       // R6
    issue(16'd0, 16'd0, 1'b0);       // R6 both zero
    issue(16'hFFFF, 16'h5555, 1'b0); // R11
    issue(16'hFFF0, 16'h7FF8, 1'b0); // R11
    issue(16'd1, 16'd7, 1'b0);       // R4
    issue(16'd1071, 16'd462, 1'b1);  // R9 stray start mid-run
    issue(16'd35, 16'd64, 1'b1);     // R9
    issue(16'h8000, 16'h8000, 1'b0); // R10 R11
    while (exp_r_q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    check(r == last_r, "R8 hold", r, last_r);
    check(ready == 1'b1, "R2 idle", ready, 1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule